// File: doc/BRIEF.md
# Read-Side Empty Flag with Read Gating

This block sits on the read side of a FIFO and decides, one read clock at a time, whether the FIFO holds no data. It compares the local read pointer with the write pointer after that pointer has been brought into the read clock domain. When the two are equal, the FIFO is empty: the next read would hit the location that the next write will fill. The result is the registered active-low flag `empty_n_o`.

The block also gates reads. A read request is turned into a registered read strobe only while the flag shows data is present. The strobe is meant to advance the read pointer and drive the memory read port. Requests made while the flag is low are dropped.

In the enhanced configuration, a second active-low empty flag is available. It is an exact copy of the main flag, one read clock later. In the standalone configuration, that output has no function and is held HIGH.

Top module: `ef_read_side`

## Requirements
- R1: While `rst_i` is sampled high on a rising clock, the next state has `empty_n_o` = 0 and `rd_stb_o` = 0. In enhanced mode `empty2_n_o` is also 0. So after reset and before any write, the FIFO reports empty.
- R2: On each rising clock, `empty_n_o` takes the value 0 if `rd_ptr_i` equals `wr_ptr_sync_i`, and 1 otherwise.
- R3: `empty_n_o` changes only at a rising clock. A pointer change between edges leaves the flag unchanged until the next edge.
- R4: On each rising clock, `rd_stb_o` takes the value of `rd_en_i` AND `empty_n_o`, using the flag value held before that edge.
- R5: While `empty_n_o` is 0, `rd_stb_o` stays 0 at the next edge regardless of `rd_en_i`.
- R6: In enhanced mode (`MODE` = `EF_MODE_ENHANCED`), `empty2_n_o` equals the value `empty_n_o` had one rising clock earlier.
- R7: In standalone mode (`MODE` = `EF_MODE_STANDALONE`), `empty2_n_o` is held at 1 at all times, including during reset.
- R8: The comparison covers every pointer bit, including the wrap bit (MSB). Pointers that differ only in the MSB, i.e. are a full depth apart, are not empty.
- R9: Reset is synchronous. Raising `rst_i` in the middle of traffic clears the flags and the strobe at the next rising clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read request |
| rd_ptr_i | input | PTR_W | Read pointer, MSB is the wrap bit |
| wr_ptr_sync_i | input | PTR_W | Write pointer synchronised to the read clock |
| empty_n_o | output | 1 | Registered empty flag, low when empty |
| empty2_n_o | output | 1 | Empty flag delayed one read clock (enhanced) or held high (standalone) |
| rd_stb_o | output | 1 | Registered, gated read strobe |

## Verification
The bench builds two copies of the block with `PTR_W` = 5, so a 16-entry FIFO with a wrap bit. With such narrow pointers, cases that differ only in the wrap bit are easy to drive directly. One copy uses the enhanced mode, so the delayed flag can be followed across sequences of empty and non-empty states. The other uses the standalone mode, with the same stimulus, to show that the second flag stays HIGH even through reset.

// File: rtl/ef_pkg.sv
package ef_pkg;
  typedef enum logic {
    EF_MODE_STANDALONE = 1'b0,
    EF_MODE_ENHANCED   = 1'b1
  } ef_mode_e;
endpackage

// File: rtl/ef_ptr_cmp.sv
module ef_ptr_cmp #(
  parameter int PTR_W = 13
) (
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  output logic             ptr_eq_o
);
  // full-width compare: wrap bit separates full from empty
  always_comb begin
    ptr_eq_o = (rd_ptr_i == wr_ptr_i);
  end
endmodule

// File: rtl/ef_flag_reg.sv
module ef_flag_reg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ptr_eq_i,
  output logic empty_n_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) empty_n_o <= 1'b0;
    else       empty_n_o <= ~ptr_eq_i;
  end

  // R2
  flag_follows_cmp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (empty_n_o == !$past(ptr_eq_i)));
  // R1
  flag_reset_low_chk: assert property (@(posedge clk_i)
    rst_i |=> !empty_n_o);
endmodule

// File: rtl/ef_rd_gate.sv
module ef_rd_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rd_en_i,
  input  logic empty_n_i,
  output logic rd_stb_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) rd_stb_o <= 1'b0;
    else       rd_stb_o <= rd_en_i & empty_n_i;
  end

  // R5
  no_read_when_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !empty_n_i |=> !rd_stb_o);
  // R4
  read_passes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en_i && empty_n_i) |=> rd_stb_o);
  // R1
  stb_reset_low_chk: assert property (@(posedge clk_i)
    rst_i |=> !rd_stb_o);
endmodule

// File: rtl/ef_flag_dly.sv
module ef_flag_dly
  import ef_pkg::*;
#(
  parameter ef_mode_e MODE = EF_MODE_ENHANCED
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic empty_n_i,
  output logic empty2_n_o
);
  generate
    if (MODE == EF_MODE_ENHANCED) begin : g_enh
      logic dly_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) dly_q <= 1'b0;
        else       dly_q <= empty_n_i;
      end
      assign empty2_n_o = dly_q;

      // R6
      lag_one_clk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> (empty2_n_o == $past(empty_n_i)));
    end else begin : g_std
      assign empty2_n_o = 1'b1;

      // R7
      held_high_chk: assert property (@(posedge clk_i) empty2_n_o);
    end
  endgenerate
endmodule

// File: rtl/ef_read_side.sv
module ef_read_side
  import ef_pkg::*;
#(
  parameter int       PTR_W = 13,
  parameter ef_mode_e MODE  = EF_MODE_ENHANCED
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rd_en_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic [PTR_W-1:0] wr_ptr_sync_i,
  output logic             empty_n_o,
  output logic             empty2_n_o,
  output logic             rd_stb_o
);
  logic ptr_eq;

  ef_ptr_cmp #(.PTR_W(PTR_W)) cmp_i (
    .rd_ptr_i (rd_ptr_i),
    .wr_ptr_i (wr_ptr_sync_i),
    .ptr_eq_o (ptr_eq)
  );

  ef_flag_reg flag_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ptr_eq_i  (ptr_eq),
    .empty_n_o (empty_n_o)
  );

  ef_rd_gate gate_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_en_i   (rd_en_i),
    .empty_n_i (empty_n_o),
    .rd_stb_o  (rd_stb_o)
  );

  ef_flag_dly #(.MODE(MODE)) dly_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .empty_n_i  (empty_n_o),
    .empty2_n_o (empty2_n_o)
  );
endmodule

// File: tb/ef_read_side_tb.sv
module ef_read_side_tb_top;
  import ef_pkg::*;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0;
  logic [PW-1:0] rd_ptr = '0;
  logic [PW-1:0] wr_ptr = '0;
  logic ef_n, ef2_n, stb;
  logic s_ef_n, s_ef2_n, s_stb;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ef_read_side #(.PTR_W(PW), .MODE(EF_MODE_ENHANCED)) dut_i (
    .clk_i(clk), .rst_i(rst), .rd_en_i(rd_en), .rd_ptr_i(rd_ptr),
    .wr_ptr_sync_i(wr_ptr), .empty_n_o(ef_n), .empty2_n_o(ef2_n), .rd_stb_o(stb));

  ef_read_side #(.PTR_W(PW), .MODE(EF_MODE_STANDALONE)) dut_std_i (
    .clk_i(clk), .rst_i(rst), .rd_en_i(rd_en), .rd_ptr_i(rd_ptr),
    .wr_ptr_sync_i(wr_ptr), .empty_n_o(s_ef_n), .empty2_n_o(s_ef2_n), .rd_stb_o(s_stb));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    rst = 1'b1; rd_en = 1'b1; rd_ptr = 5'd1; wr_ptr = 5'd7;
    tick(); tick();
    chk("R1 flag", ef_n, 1'b0);
    chk("R1 flag2", ef2_n, 1'b0);
    chk("R1 stb", stb, 1'b0);
    chk("R7 std flag2 in reset", s_ef2_n, 1'b1);
    rd_en = 1'b0; rd_ptr = 5'd0; wr_ptr = 5'd0;
    rst = 1'b0;
    tick();
    chk("R1 empty before write", ef_n, 1'b0);
  endtask

  task automatic test_track();
    rd_ptr = 5'd3; wr_ptr = 5'd3; tick();
    chk("R2 equal", ef_n, 1'b0);
    wr_ptr = 5'd4; tick();
    chk("R2 differ", ef_n, 1'b1);
    rd_ptr = 5'd4; tick();
    chk("R2 caught up", ef_n, 1'b0);
  endtask

  task automatic test_edge_only();
    rd_ptr = 5'd9; wr_ptr = 5'd12; tick();
    chk("R3 setup", ef_n, 1'b1);
    wr_ptr = 5'd9; #2;
    chk("R3 no change between edges", ef_n, 1'b1);
    tick();
    chk("R3 change after edge", ef_n, 1'b0);
  endtask

  task automatic test_wrap();
    rd_ptr = 5'b00010; wr_ptr = 5'b10010; tick();
    chk("R8 msb differs", ef_n, 1'b1);
    rd_ptr = 5'b10010; tick();
    chk("R8 msb equal", ef_n, 1'b0);
  endtask

  task automatic test_strobe();
    rd_ptr = 5'd0; wr_ptr = 5'd5; tick();
    rd_en = 1'b1; tick();
    chk("R4 strobe on", stb, 1'b1);
    rd_en = 1'b0; tick();
    chk("R4 strobe off", stb, 1'b0);
  endtask

  task automatic test_block();
    rd_ptr = 5'd6; wr_ptr = 5'd6; tick();
    chk("R5 flag low", ef_n, 1'b0);
    rd_en = 1'b1; tick();
    chk("R5 blocked", stb, 1'b0);
    tick();
    chk("R5 still blocked", stb, 1'b0);
    chk("R5 std blocked", s_stb, 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic test_delay();
    logic prev;
    prev = ef_n;
    for (int i = 0; i < 6; i++) begin
      wr_ptr = (i % 3 == 1) ? rd_ptr : rd_ptr + 5'd1;
      tick();
      chk("R6 lag", ef2_n, prev);
      chk("R7 std held", s_ef2_n, 1'b1);
      prev = ef_n;
    end
  endtask

  task automatic test_mid_reset();
    rd_ptr = 5'd2; wr_ptr = 5'd8; rd_en = 1'b1; tick(); tick();
    chk("R9 pre stb", stb, 1'b1);
    rst = 1'b1; tick();
    chk("R9 flag", ef_n, 1'b0);
    chk("R9 flag2", ef2_n, 1'b0);
    chk("R9 stb", stb, 1'b0);
    rst = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset_state();
    test_track();
    test_edge_only();
    test_wrap();
    test_strobe();
    test_block();
    test_delay();
    test_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule